// File: doc/BRIEF.md
# Memory range decoder with reflection

This unit takes a 40-bit physical request address and decides where the request goes. The three possible destinations are local memory, memory-mapped I/O, or the compatibility bus. A set of programmable memory ranges is checked against the address, and each range has a base, an inclusive limit and an interleave code. A low and a high MMIO window are checked alongside them. For a memory hit, the unit also returns a device-relative address and an interleave way.

A range can be flagged as a reflection. A reflection is an upper-address window that aliases a source range, so that memory hidden behind the low MMIO hole can still be reached. Translation keeps address bits [31:0] and replaces the upper bits with those of the source range's limit. Offset and interleave are then taken from the source range. A reflected hit that lands on memory the OS can already see directly is tagged as an illegal alias.

A rule checker re-evaluates the reflection programming rules after every register write. It raises a sticky configuration error until software clears it. Requests and responses each use a valid/ready handshake, and a response appears one cycle after the request is accepted.

Top module: `mem_route_dec`

## Requirements
- R1: After reset there is no response valid, `req_ready_o` is 1, `cfg_err_o` is 0, no range is enabled and both MMIO windows are empty (base all ones, limit 0), so any request routes to the compatibility bus.
- R2: A request is accepted when `req_valid_i` and `req_ready_o` are both 1, and its response is valid after the next rising edge. `req_ready_o` is 1 exactly when no response is held or `rsp_ready_i` is 1. A response that is not taken holds all of its fields. `rsp_wr_o` returns the request's write qualifier.
- R3: An address with base <= addr <= limit for the low or the high MMIO window routes as MMIO (route code 2), whatever memory range it also falls in. Index, way, device address and alias flag are 0 for MMIO.
- R4: Otherwise the enabled range with the lowest index whose base <= addr <= limit wins. The route code is 1 and `rsp_idx_o` carries that index.
- R5: An address that matches neither an MMIO window nor an enabled range routes to the compatibility bus (route code 0). Index, way, device address and alias flag are all 0.
- R6: For a memory hit with interleave code k, the offset is off = addr − base. The way is bits off[6 +: k] (with k=0 giving way 0). The device address is ((off >> (6+k)) << 6) | off[5:0].
- R7: When the winning range is a reflection with source index s, the translated address is {limit[s][39:32], addr[31:0]}. Base and interleave code are then those of range s. `rsp_idx_o` reports the reflection range.
- R8: `rsp_alias_err_o` is 1 on a reflected hit whose translated address lies outside the low MMIO window or outside range s. It is 0 in every other case.
- R9: An enabled reflection with limit < base, or with limit − base greater than FFFF_FFFFh (a span larger than 4 GB), is a configuration error. A span of exactly 4 GB is legal.
- R10: An enabled reflection is a configuration error if its limit bits [31:0] are not all ones, or if the limit bits [31:0] of its source are not all ones.
- R11: An enabled reflection is a configuration error if its interleave code differs from its source's, if its source is not enabled, or if its source is itself a reflection.
- R12: The rules are evaluated on the cycle after each register write, and `cfg_err_o` rises on the following edge if any rule fails. The flag then stays set until a `cfg_err_clr_i` pulse. If an evaluation that fails coincides with a clear, the flag stays set. A write that leaves every rule satisfied does not set the flag.
- R13: `cfg_addr_i[4:2]` selects a slot and `cfg_addr_i[1:0]` selects a field. Slots 0..3 are ranges, with field 0 for base, 1 for limit and 2 for attributes. The attribute bits are: [0] enable, [1] reflection, [3:2] interleave code, [5:4] source index. Slot 4 holds the MMIO windows: field 0 is low base, 1 is low limit, 2 is high base and 3 is high limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 5 | Register slot and field |
| cfg_wdata_i | input | 40 | Register write data |
| cfg_err_clr_i | input | 1 | Clears the configuration error flag |
| cfg_err_o | output | 1 | Sticky configuration error |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | 40 | Request physical address |
| req_wr_i | input | 1 | Request is a write |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_route_o | output | 2 | 0 compatibility bus, 1 memory, 2 MMIO |
| rsp_idx_o | output | 2 | Winning range index |
| rsp_way_o | output | 3 | Interleave way |
| rsp_dev_addr_o | output | 40 | Device-relative address |
| rsp_alias_err_o | output | 1 | Illegal reflected alias |
| rsp_wr_o | output | 1 | Write qualifier of the request |

## Verification
A corrupted range or window register shows up in the very next response for any address near that register's bounds. It appears as a wrong route code, a wrong winning index, or a device address that is shifted by the wrong base. Broken reflection wiring shows up as upper address bits that do not match the source limit, or as an alias flag that is set on the wrong half of the reflected window. A fault in the rule evaluation shows up on `cfg_err_o` two edges after the offending write: it fails to rise, rises on a legal 4 GB span, or drops while a clear coincides with a failed evaluation. The address sweep steps through every 256 MB boundary of a 16 GB space. It therefore crosses each programmed base, limit and window edge with a one-below, at-edge and in-line probe.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  typedef enum logic [1:0] {
    ROUTE_COMPAT = 2'd0,
    ROUTE_MEM    = 2'd1,
    ROUTE_MMIO   = 2'd2
  } route_e;

  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_LIMIT = 2'd1,
    FLD_ATTR  = 2'd2
  } fld_e;
endpackage

// File: rtl/mrd_cfg_regs.sv
module mrd_cfg_regs #(
  parameter int unsigned AW     = 40,
  parameter int unsigned N      = 4,
  parameter int unsigned ILV_W  = 2,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned CFG_AW = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [CFG_AW-1:0]        addr_i,
  input  logic [AW-1:0]            wdata_i,
  input  logic                     err_clr_i,
  output logic                     err_o,
  output logic [N-1:0][AW-1:0]     base_o,
  output logic [N-1:0][AW-1:0]     limit_o,
  output logic [N-1:0]             valid_o,
  output logic [N-1:0]             refl_o,
  output logic [N-1:0][ILV_W-1:0]  ilv_o,
  output logic [N-1:0][IDX_W-1:0]  src_o,
  output logic [AW-1:0]            mlo_base_o,
  output logic [AW-1:0]            mlo_lim_o,
  output logic [AW-1:0]            mhi_base_o,
  output logic [AW-1:0]            mhi_lim_o
);
  import mrd_pkg::*;
  localparam int unsigned SLOT_W = CFG_AW - 2;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        fld;
  logic [N-1:0]      viol;
  logic              eval_q, err_q;

  assign slot = addr_i[CFG_AW-1:2];
  assign fld  = addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o     <= '0;
      limit_o    <= '0;
      valid_o    <= '0;
      refl_o     <= '0;
      ilv_o      <= '0;
      src_o      <= '0;
      mlo_base_o <= '1;
      mlo_lim_o  <= '0;
      mhi_base_o <= '1;
      mhi_lim_o  <= '0;
    end else if (we_i) begin
      for (int r = 0; r < N; r++) begin
        if (slot == SLOT_W'(r)) begin
          case (fld)
            FLD_BASE:  base_o[r]  <= wdata_i;
            FLD_LIMIT: limit_o[r] <= wdata_i;
            FLD_ATTR: begin
              valid_o[r] <= wdata_i[0];
              refl_o[r]  <= wdata_i[1];
              ilv_o[r]   <= wdata_i[2 +: ILV_W];
              src_o[r]   <= wdata_i[2+ILV_W +: IDX_W];
            end
            default: ;
          endcase
        end
      end
      if (slot == SLOT_W'(N)) begin
        case (fld)
          2'd0: mlo_base_o <= wdata_i;
          2'd1: mlo_lim_o  <= wdata_i;
          2'd2: mhi_base_o <= wdata_i;
          default: mhi_lim_o <= wdata_i;
        endcase
      end
    end
  end

  // reflection programming rules, one checker per range
  for (genvar r = 0; r < N; r++) begin : g_rule
    logic [AW-1:0]    span;
    logic [IDX_W-1:0] s;
    assign s    = src_o[r];
    assign span = limit_o[r] - base_o[r];
    assign viol[r] = valid_o[r] & refl_o[r] &
                     ((limit_o[r] < base_o[r]) | (|span[AW-1:32]) |
                      ~(&limit_o[r][31:0]) | ~(&limit_o[s][31:0]) |
                      (ilv_o[r] != ilv_o[s]) | ~valid_o[s] | refl_o[s]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eval_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      eval_q <= we_i;
      if (eval_q && (|viol)) err_q <= 1'b1;
      else if (err_clr_i)    err_q <= 1'b0;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/mrd_range_match.sv
module mrd_range_match #(
  parameter int unsigned AW    = 40,
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [AW-1:0]          addr_i,
  input  logic [N-1:0][AW-1:0]   base_i,
  input  logic [N-1:0][AW-1:0]   limit_i,
  input  logic [N-1:0]           valid_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [N-1:0] hv;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hv[i] = valid_i[i] && (addr_i >= base_i[i]) && (addr_i <= limit_i[i]);
  end

  // lowest index wins
  always_comb begin
    hit_o = |hv;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hv[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mrd_xlate.sv
module mrd_xlate #(
  parameter int unsigned AW      = 40,
  parameter int unsigned ILV_W   = 2,
  parameter int unsigned WAY_W   = 3,
  parameter int unsigned LINE_SH = 6
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [AW-1:0]    base_i,
  input  logic [ILV_W-1:0] ilv_i,
  output logic [WAY_W-1:0] way_o,
  output logic [AW-1:0]    dev_o
);
  localparam logic [AW-1:0] LINE_MASK = AW'((64'd1 << LINE_SH) - 64'd1);

  logic [AW-1:0]    off;
  logic [WAY_W-1:0] way_mask;

  assign off      = addr_i - base_i;
  assign way_mask = WAY_W'((32'd1 << ilv_i) - 32'd1);
  assign way_o    = WAY_W'(off >> LINE_SH) & way_mask;
  assign dev_o    = ((off >> (LINE_SH + ilv_i)) << LINE_SH) | (off & LINE_MASK);
endmodule

// File: rtl/mem_route_dec.sv
module mem_route_dec #(
  parameter int unsigned ADDR_W  = 40,
  parameter int unsigned N_RANGE = 4,
  parameter int unsigned ILV_W   = 2,
  parameter int unsigned LINE_SH = 6,
  localparam int unsigned IDX_W  = (N_RANGE > 1) ? $clog2(N_RANGE) : 1,
  localparam int unsigned WAY_W  = (1 << ILV_W) - 1,
  localparam int unsigned CFG_AW = $clog2(N_RANGE + 1) + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [ADDR_W-1:0]  cfg_wdata_i,
  input  logic               cfg_err_clr_i,
  output logic               cfg_err_o,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_wr_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [1:0]         rsp_route_o,
  output logic [IDX_W-1:0]   rsp_idx_o,
  output logic [WAY_W-1:0]   rsp_way_o,
  output logic [ADDR_W-1:0]  rsp_dev_addr_o,
  output logic               rsp_alias_err_o,
  output logic               rsp_wr_o
);
  import mrd_pkg::*;

  logic [N_RANGE-1:0][ADDR_W-1:0] base_r, limit_r;
  logic [N_RANGE-1:0]             valid_r, refl_r;
  logic [N_RANGE-1:0][ILV_W-1:0]  ilv_r;
  logic [N_RANGE-1:0][IDX_W-1:0]  src_r;
  logic [ADDR_W-1:0]              mlo_base, mlo_lim, mhi_base, mhi_lim;

  mrd_cfg_regs #(
    .AW(ADDR_W), .N(N_RANGE), .ILV_W(ILV_W), .IDX_W(IDX_W), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .err_clr_i(cfg_err_clr_i), .err_o(cfg_err_o),
    .base_o(base_r), .limit_o(limit_r), .valid_o(valid_r), .refl_o(refl_r),
    .ilv_o(ilv_r), .src_o(src_r),
    .mlo_base_o(mlo_base), .mlo_lim_o(mlo_lim),
    .mhi_base_o(mhi_base), .mhi_lim_o(mhi_lim)
  );

  logic              hit, mmio_hit, is_mem, sel_refl, alias_bad;
  logic [IDX_W-1:0]  hit_idx, src;
  logic [ADDR_W-1:0] refl_addr, eff_addr, eff_base, dev_addr;
  logic [ILV_W-1:0]  eff_ilv;
  logic [WAY_W-1:0]  way;
  route_e            route_d;

  assign mmio_hit = ((req_addr_i >= mlo_base) && (req_addr_i <= mlo_lim)) ||
                    ((req_addr_i >= mhi_base) && (req_addr_i <= mhi_lim));

  mrd_range_match #(.AW(ADDR_W), .N(N_RANGE), .IDX_W(IDX_W)) u_match (
    .addr_i(req_addr_i), .base_i(base_r), .limit_i(limit_r), .valid_i(valid_r),
    .hit_o(hit), .idx_o(hit_idx)
  );

  // reflection: keep low 32 bits, take upper bits from the source limit
  assign sel_refl  = refl_r[hit_idx];
  assign src       = src_r[hit_idx];
  assign refl_addr = {limit_r[src][ADDR_W-1:32], req_addr_i[31:0]};
  assign eff_addr  = sel_refl ? refl_addr    : req_addr_i;
  assign eff_base  = sel_refl ? base_r[src]  : base_r[hit_idx];
  assign eff_ilv   = sel_refl ? ilv_r[src]   : ilv_r[hit_idx];
  assign alias_bad = sel_refl &&
                     !((refl_addr >= mlo_base) && (refl_addr <= mlo_lim) &&
                       (refl_addr >= base_r[src]) && (refl_addr <= limit_r[src]));

  mrd_xlate #(.AW(ADDR_W), .ILV_W(ILV_W), .WAY_W(WAY_W), .LINE_SH(LINE_SH)) u_xlate (
    .addr_i(eff_addr), .base_i(eff_base), .ilv_i(eff_ilv), .way_o(way), .dev_o(dev_addr)
  );

  assign is_mem  = !mmio_hit && hit;
  assign route_d = mmio_hit ? ROUTE_MMIO : (hit ? ROUTE_MEM : ROUTE_COMPAT);

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o     <= 1'b0;
      rsp_route_o     <= ROUTE_COMPAT;
      rsp_idx_o       <= '0;
      rsp_way_o       <= '0;
      rsp_dev_addr_o  <= '0;
      rsp_alias_err_o <= 1'b0;
      rsp_wr_o        <= 1'b0;
    end else if (req_ready_o) begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_route_o     <= route_d;
        rsp_idx_o       <= is_mem ? hit_idx   : '0;
        rsp_way_o       <= is_mem ? way       : '0;
        rsp_dev_addr_o  <= is_mem ? dev_addr  : '0;
        rsp_alias_err_o <= is_mem && alias_bad;
        rsp_wr_o        <= req_wr_i;
      end
    end
  end
endmodule

// File: rtl/mem_route_dec_chk.sv
module mem_route_dec_chk #(
  parameter int unsigned ADDR_W  = 40,
  parameter int unsigned N_RANGE = 4,
  parameter int unsigned ILV_W   = 2,
  parameter int unsigned LINE_SH = 6,
  localparam int unsigned IDX_W  = (N_RANGE > 1) ? $clog2(N_RANGE) : 1,
  localparam int unsigned WAY_W  = (1 << ILV_W) - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              cfg_err_clr_i,
  input logic              cfg_err_o,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [1:0]        rsp_route_o,
  input logic [IDX_W-1:0]  rsp_idx_o,
  input logic [WAY_W-1:0]  rsp_way_o,
  input logic [ADDR_W-1:0] rsp_dev_addr_o,
  input logic              rsp_alias_err_o
);
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_route_o) &&
    $stable(rsp_idx_o) && $stable(rsp_way_o) && $stable(rsp_dev_addr_o) &&
    $stable(rsp_alias_err_o));

  p_route_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_route_o != 2'd3);

  p_alias_mem_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_route_o != 2'd1 |-> !rsp_alias_err_o && rsp_dev_addr_o == '0 &&
    rsp_way_o == '0);

  p_err_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o && !cfg_err_clr_i |=> cfg_err_o);

  p_err_cause_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> $past(cfg_we_i, 2));
endmodule

bind mem_route_dec mem_route_dec_chk #(
  .ADDR_W(ADDR_W), .N_RANGE(N_RANGE), .ILV_W(ILV_W), .LINE_SH(LINE_SH)
) u_chk (.*);

// File: tb/tb_mem_route_dec.sv
`timescale 1ns/1ps
module tb_mem_route_dec;
  localparam int AW = 40;
  localparam int N  = 4;
  localparam int LSH = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cfg_we = 0, cfg_clr = 0, cfg_err;
  logic [4:0]    cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          req_valid = 0, req_ready, req_wr = 0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid, rsp_ready = 1, rsp_alias, rsp_wr;
  logic [1:0]    rsp_route, rsp_idx;
  logic [2:0]    rsp_way;
  logic [AW-1:0] rsp_dev;

  mem_route_dec dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_err_clr_i(cfg_clr), .cfg_err_o(cfg_err),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr), .req_wr_i(req_wr),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_route_o(rsp_route),
    .rsp_idx_o(rsp_idx), .rsp_way_o(rsp_way), .rsp_dev_addr_o(rsp_dev),
    .rsp_alias_err_o(rsp_alias), .rsp_wr_o(rsp_wr)
  );

  int errs = 0, checks = 0;
  bit done = 0;

  logic [AW-1:0] m_base[N], m_lim[N];
  logic          m_val[N], m_refl[N];
  logic [1:0]    m_ilv[N], m_src[N];
  logic [AW-1:0] m_lb = '1, m_ll = '0, m_hb = '1, m_hl = '0;

  initial begin
    for (int i = 0; i < N; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_val[i] = 0; m_refl[i] = 0; m_ilv[i] = 0; m_src[i] = 0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [AW-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  // write then let the evaluation edge pass
  task automatic cfg_write_settle(input logic [4:0] a, input logic [AW-1:0] d);
    cfg_write(a, d);
    @(negedge clk);
  endtask

  task automatic err_clear();
    @(negedge clk); cfg_clr = 1;
    @(negedge clk); cfg_clr = 0;
  endtask

  task automatic set_base(input int r, input logic [AW-1:0] b);
    m_base[r] = b; cfg_write_settle({r[2:0], 2'd0}, b);
  endtask
  task automatic set_lim(input int r, input logic [AW-1:0] l);
    m_lim[r] = l; cfg_write_settle({r[2:0], 2'd1}, l);
  endtask
  task automatic set_attr(input int r, input bit v, input bit rf, input int il, input int s);
    m_val[r] = v; m_refl[r] = rf; m_ilv[r] = il[1:0]; m_src[r] = s[1:0];
    cfg_write_settle({r[2:0], 2'd2}, AW'({s[1:0], il[1:0], rf, v}));
  endtask

  function automatic void model(input logic [AW-1:0] a, output logic [1:0] r,
                                output logic [1:0] ix, output logic [2:0] w,
                                output logic [AW-1:0] d, output logic al);
    logic [AW-1:0] t, b, off;
    int il, s, hit;
    r = 0; ix = 0; w = 0; d = 0; al = 0; hit = -1;
    if ((a >= m_lb && a <= m_ll) || (a >= m_hb && a <= m_hl)) begin r = 2; return; end
    for (int i = N - 1; i >= 0; i--) if (m_val[i] && a >= m_base[i] && a <= m_lim[i]) hit = i;
    if (hit < 0) return;
    r = 1; ix = hit[1:0];
    if (m_refl[hit]) begin
      s = int'(m_src[hit]);
      t = {m_lim[s][AW-1:32], a[31:0]};
      al = !((t >= m_lb && t <= m_ll) && (t >= m_base[s] && t <= m_lim[s]));
    end else begin
      s = hit; t = a;
    end
    b = m_base[s]; il = int'(m_ilv[s]); off = t - b;
    w = 3'((off >> LSH) & ((40'd1 << il) - 40'd1));
    d = ((off >> (LSH + il)) << LSH) | (off & 40'h3F);
  endfunction

  task automatic do_req(input logic [AW-1:0] a);
    logic [1:0] er, ei; logic [2:0] ew; logic [AW-1:0] ed; logic ea;
    string tg, xt;
    model(a, er, ei, ew, ed, ea);
    @(negedge clk); req_valid = 1; req_addr = a; req_wr = a[6]; rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    tg = (er == 2) ? "R3" : (er == 0) ? "R5" : m_refl[ei] ? "R7" : "R4";
    xt = (er == 1 && m_refl[ei]) ? "R7" : "R6";
    chk({tg, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tg, " route"}, 64'(rsp_route), 64'(er));
    chk({tg, " idx"}, 64'(rsp_idx), 64'(ei));
    chk({xt, " way"}, 64'(rsp_way), 64'(ew));
    chk({xt, " dev"}, 64'(rsp_dev), 64'(ed));
    chk("R8 alias", 64'(rsp_alias), 64'(ea));
    chk("R2 wr", 64'(rsp_wr), 64'(a[6]));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] offs[3];
    offs[0] = 40'h0; offs[1] = 40'h1C0; offs[2] = 40'h0FFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 err", 64'(cfg_err), 64'd0);
    chk("R1 ready", 64'(req_ready), 64'd1);
    do_req(40'h0_8000_0040);
    chk("R1 compat after reset", 64'(rsp_route), 64'd0);

    // R13 programming: windows then ranges, reflection last
    m_lb = 40'h0_C000_0000; cfg_write_settle(5'b100_00, m_lb);
    m_ll = 40'h0_FFFF_FFFF; cfg_write_settle(5'b100_01, m_ll);
    m_hb = 40'h3_8000_0000; cfg_write_settle(5'b100_10, m_hb);
    m_hl = 40'h3_8FFF_FFFF; cfg_write_settle(5'b100_11, m_hl);
    set_base(0, 40'h0_8000_0000); set_lim(0, 40'h0_FFFF_FFFF); set_attr(0, 1, 0, 1, 0);
    set_base(2, 40'h0_0000_0000); set_lim(2, 40'h0_7FFF_FFFF); set_attr(2, 1, 0, 0, 0);
    set_base(3, 40'h1_C000_0000); set_lim(3, 40'h2_FFFF_FFFF); set_attr(3, 1, 0, 2, 0);
    set_base(1, 40'h1_8000_0000); set_lim(1, 40'h1_FFFF_FFFF); set_attr(1, 1, 1, 1, 0);
    chk("R12 legal programming sets no error", 64'(cfg_err), 64'd0);

    // near-exhaustive sweep over 16 GB in 256 MB steps
    for (int k = 0; k < 64; k++)
      for (int j = 0; j < 3; j++)
        do_req(AW'(k) * 40'h1000_0000 + offs[j]);
    do_req(40'h1_BFFF_FFFF);
    do_req(40'h1_C000_0000);
    do_req(40'h0_BFFF_FFC0);

    // R2 back-pressure
    @(negedge clk); rsp_ready = 0; req_valid = 1; req_addr = 40'h0_8000_00C0; req_wr = 1;
    @(negedge clk); req_addr = 40'h3_8000_0000; req_wr = 0;
    chk("R2 response after accept", 64'(rsp_valid), 64'd1);
    chk("R2 ready low while held", 64'(req_ready), 64'd0);
    repeat (3) @(negedge clk);
    chk("R2 held route", 64'(rsp_route), 64'd1);
    chk("R2 held dev", 64'(rsp_dev), 64'h40);
    chk("R2 held way", 64'(rsp_way), 64'd1);
    chk("R2 held wr", 64'(rsp_wr), 64'd1);
    rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    chk("R2 next response", 64'(rsp_route), 64'd2);
    chk("R2 next valid", 64'(rsp_valid), 64'd1);
    @(negedge clk);
    chk("R2 drained", 64'(rsp_valid), 64'd0);

    // R11 interleave mismatch
    set_base(2, 40'h2_8000_0000); set_lim(2, 40'h2_FFFF_FFFF);
    chk("R12 non-reflection edits set no error", 64'(cfg_err), 64'd0);
    set_attr(2, 1, 1, 0, 0);
    chk("R11 interleave mismatch", 64'(cfg_err), 64'd1);
    repeat (3) @(negedge clk);
    chk("R12 flag holds", 64'(cfg_err), 64'd1);
    err_clear();
    chk("R12 clear", 64'(cfg_err), 64'd0);
    set_attr(2, 1, 1, 1, 0);
    chk("R11 matching interleave legal", 64'(cfg_err), 64'd0);
    // R9 span
    set_lim(2, 40'h3_FFFF_FFFF);
    chk("R9 span over 4GB", 64'(cfg_err), 64'd1);
    err_clear();
    set_base(2, 40'h2_0000_0000);
    chk("R9 span 8GB", 64'(cfg_err), 64'd1);
    err_clear();
    set_lim(2, 40'h2_FFFF_FFFF);
    chk("R9 exact 4GB legal", 64'(cfg_err), 64'd0);
    set_lim(2, 40'h1_FFFF_FFFF);
    chk("R9 limit below base", 64'(cfg_err), 64'd1);
    err_clear();
    // R10 alignment
    set_lim(2, 40'h2_FFFF_FFFE);
    chk("R10 misaligned limit", 64'(cfg_err), 64'd1);
    err_clear();
    set_lim(2, 40'h2_FFFF_FFFF);
    chk("R10 aligned limit legal", 64'(cfg_err), 64'd0);
    set_lim(0, 40'h0_FFFF_FFF0);
    chk("R10 misaligned source", 64'(cfg_err), 64'd1);
    err_clear();
    set_lim(0, 40'h0_FFFF_FFFF);
    chk("R10 source restored", 64'(cfg_err), 64'd0);
    // R11 source kind
    set_attr(2, 1, 1, 1, 1);
    chk("R11 source is reflection", 64'(cfg_err), 64'd1);
    err_clear();
    chk("R12 clear again", 64'(cfg_err), 64'd0);
    // R12 failing evaluation beats a coincident clear
    cfg_write(5'b100_10, m_hb);
    cfg_clr = 1;
    @(negedge clk); cfg_clr = 0;
    chk("R12 set wins over clear", 64'(cfg_err), 64'd1);
    err_clear();
    chk("R12 final clear", 64'(cfg_err), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule